// File: doc/BRIEF.md
# Clock Control Register Block

This block is the software-visible register file of a clock control unit. It holds the configuration words that firmware uses to program phase-locked loops, their bias and tuning settings, the bus clock divider settings, a memory-controller configuration word and two PLL settle-time counters. No clock is generated here. The block keeps the words, returns them on reads, applies the few side effects software relies on, and flags accesses that land outside the decoded window.

A single 32-bit word port carries reads and writes. Both use one byte address; bits [1:0] are ignored, so the word index is the address shifted right by two. Read data comes back registered one cycle after the read strobe, with a valid flag. A small access state machine tracks that response: `ST_IDLE` (no read data pending) and `ST_RESP` (read data on the bus this cycle). A read strobe in either state moves to `ST_RESP` (transitions "issue" from `ST_IDLE`, "chain" from `ST_RESP`). A cycle without a read strobe moves to `ST_IDLE` (transitions "drain" from `ST_RESP`, "rest" from `ST_IDLE`).

Top module: `ccr_top`

## Requirements
- R1: After reset every named word reads its reset value: PLL controls at byte 0x000 and 0x020 read 0x00001000; 0x008 reads 0x00035514; 0x010, 0x018, 0x038 and 0x048 read 0x03006207; 0x028 and 0x044 read 0x00041811; 0x050 reads 0x00010000; 0x054 reads 0x00001010; 0x058 reads 0x01000000; 0x0F4 reads 0; 0x0FC reads 0x80000000; 0x200 and 0x204 read 0x000000FF; 0x220 reads 0x08100200; 0x230 reads 0x81104000; 0x234 and 0x244 read 0x10100010; 0x224, 0x228, 0x22C, 0x23C and 0x248 read 0x10100000; 0x250 reads 0x0A101000; 0x260 reads 0x14880000; every other offset below 0x308 reads 0.
- R2: `rvalid` is high in exactly the cycles that follow a cycle with `rd_en` high, and `rdata` then holds the word addressed in that read cycle.
- R3: A write below 0x308 stores all 32 bits of `wdata`, except for the side effects in R4 and R5, and address bits [1:0] are ignored for reads and writes.
- R4: A write to one of the PLL control words (bytes 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x038, 0x044, 0x048) with bit 31 set stores bit 28 as 1; with bit 31 clear the value is stored unchanged.
- R5: A write to the memory configuration word at 0x0F4 stores bit 16 as 0, so that bit always reads 0.
- R6: A read at byte address 0x308 or above returns 0 and raises `oob_err` for one cycle, aligned with `rvalid`.
- R7: A write at 0x308 or above changes no stored word and raises `oob_err` for one cycle, in the cycle after the write.
- R8: A write below 0x308 to an offset that is not one of the named words in R1 is stored and reads back, and raises `unimpl_wr` for one cycle in the cycle after the write; writes to named words and reads never raise it.
- R9: When a read and a write hit the same address in one cycle, the read returns the old word and the new word is visible to the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address shared by read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| oob_err | output | 1 | Pulse: previous access was at or above 0x308 |
| unimpl_wr | output | 1 | Pulse: previous write hit an unnamed offset in the window |

## Verification
The bound checker watches, on every cycle, the read-response timing, the zero data and error pulse for out-of-window reads, the error pulse for out-of-window writes and its absence otherwise, the lock bit after an enabling write to the first PLL word, the masked update bit on the memory configuration word, and the flag for a write to an unnamed offset. Full reset contents, the lock rule on every PLL word, write discard above the window, low-address-bit aliasing and read-before-write ordering on a shared address need stored history, so only the bench's scenarios show them. The bench compares every access against a model of the register contents.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
package ccr_pkg;

    localparam int WORD_W       = 32;
    localparam int PLL_EN_BIT   = 31;
    localparam int PLL_LOCK_BIT = 28;
    localparam int DRAM_UPD_BIT = 16;
    localparam int DRAM_IDX     = 61;   // byte 0x0F4

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_t;

    typedef struct packed {
        logic in_range;
        logic pll;
        logic dram;
        logic named;
    } addr_class_t;

    // PLL control words (word index = byte offset / 4)
    function automatic logic idx_is_pll(int idx);
        return idx inside {0, 2, 4, 6, 8, 10, 14, 17, 18};
    endfunction

    function automatic logic idx_is_named(int idx);
        return idx_is_pll(idx) ||
               idx inside {20, 21, 22, 61, 63, 128, 129,
                           136, 137, 138, 139, 140, 141, 143, 145, 146,
                           148, 152};
    endfunction

    function automatic logic [WORD_W-1:0] reset_word(int idx);
        logic [WORD_W-1:0] v;
        case (idx)
            0, 8:               v = 32'h0000_1000;
            2:                  v = 32'h0003_5514;
            4, 6, 14, 18:       v = 32'h0300_6207;
            10, 17:             v = 32'h0004_1811;
            20:                 v = 32'h0001_0000;
            21:                 v = 32'h0000_1010;
            22:                 v = 32'h0100_0000;
            63:                 v = 32'h8000_0000;
            128, 129:           v = 32'h0000_00FF;
            136:                v = 32'h0810_0200;
            140:                v = 32'h8110_4000;
            141, 145:           v = 32'h1010_0010;
            137, 138, 139, 143, 146: v = 32'h1010_0000;
            148:                v = 32'h0A10_1000;
            152:                v = 32'h1488_0000;
            default:            v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ccr_decode.sv
`timescale 1ns/1ps
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WIN_BYTES = 'h308,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output addr_class_t       cls
);

    always_comb begin
        idx          = addr[ADDR_W-1:2];
        cls.in_range = (addr < ADDR_W'(WIN_BYTES));
        cls.pll      = cls.in_range && idx_is_pll(int'(idx));
        cls.dram     = cls.in_range && (int'(idx) == DRAM_IDX);
        cls.named    = cls.in_range && idx_is_named(int'(idx));
    end

endmodule

// File: rtl/ccr_wshape.sv
`timescale 1ns/1ps
module ccr_wshape
    import ccr_pkg::*;
(
    input  logic              is_pll,
    input  logic              is_dram,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] wshaped
);

    always_comb begin
        wshaped = wdata;
        if (is_pll && wdata[PLL_EN_BIT]) begin
            wshaped[PLL_LOCK_BIT] = 1'b1;
        end
        if (is_dram) begin
            wshaped[DRAM_UPD_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/ccr_store.sv
`timescale 1ns/1ps
module ccr_store
    import ccr_pkg::*;
#(
    parameter int NREGS  = 194,
    parameter int IDX_W  = 10,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wword,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rword
);

    logic [NREGS-1:0][WORD_W-1:0] flat;

    for (genvar i = 0; i < NREGS; i++) begin : g_word
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= reset_word(i);
            end else if (we && (widx == IDX_W'(i))) begin
                q <= wword;
            end
        end
        assign flat[i] = q;
    end

    always_comb begin
        if (int'(ridx) < NREGS) begin
            rword = flat[ridx[SEL_W-1:0]];
        end else begin
            rword = '0;
        end
    end

endmodule

// File: rtl/ccr_top.sv
`timescale 1ns/1ps
module ccr_top
    import ccr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WIN_BYTES = 'h308,
    localparam int IDX_W    = ADDR_W - 2,
    localparam int NREGS    = WIN_BYTES / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    output logic              oob_err,
    output logic              unimpl_wr
);

    bus_state_t        state_q, state_d;
    addr_class_t       cls;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] wshaped;
    logic [WORD_W-1:0] rword;
    logic [WORD_W-1:0] rdata_q;
    logic              oob_q;
    logic              unimpl_q;

    ccr_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_decode (
        .addr (addr),
        .idx  (idx),
        .cls  (cls)
    );

    ccr_wshape u_wshape (
        .is_pll  (cls.pll),
        .is_dram (cls.dram),
        .wdata   (wdata),
        .wshaped (wshaped)
    );

    ccr_store #(.NREGS(NREGS), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && cls.in_range),
        .widx  (idx),
        .wword (wshaped),
        .ridx  (idx),
        .rword (rword)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: issue / chain on a read strobe, rest / drain otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_en ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_en ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Response data and pulse flags, captured with the access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            oob_q    <= 1'b0;
            unimpl_q <= 1'b0;
        end else begin
            if (rd_en) begin
                rdata_q <= cls.in_range ? rword : '0;
            end
            oob_q    <= (rd_en || wr_en) && !cls.in_range;
            unimpl_q <= wr_en && cls.in_range && !cls.named;
        end
    end

    // Outputs
    always_comb begin
        rvalid    = (state_q == ST_RESP);
        rdata     = rdata_q;
        oob_err   = oob_q;
        unimpl_wr = unimpl_q;
    end

endmodule

// File: rtl/ccr_chk.sv
`timescale 1ns/1ps
module ccr_chk #(
    parameter int ADDR_W    = 12,
    parameter int WIN_BYTES = 'h308
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wdata_en_bit,
    input logic [31:0]       rdata,
    input logic              rvalid,
    input logic              oob_err,
    input logic              unimpl_wr
);

    logic oob_acc;
    logic [ADDR_W-3:0] widx;
    assign oob_acc = (rd_en || wr_en) && (addr >= ADDR_W'(WIN_BYTES));
    assign widx    = addr[ADDR_W-1:2];

    assert_rvalid_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    assert_rvalid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    assert_oob_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= ADDR_W'(WIN_BYTES)) |=> (rdata == '0) && oob_err);

    assert_oob_write_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= ADDR_W'(WIN_BYTES)) |=> oob_err);

    assert_no_spurious_oob_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !oob_acc |=> !oob_err);

    assert_pll_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && widx == '0 &&
         $past(wr_en && widx == '0 && wdata_en_bit)) |=> rdata[28]);

    assert_dram_update_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && widx == (ADDR_W-2)'(61)) |=> !rdata[16]);

    assert_unnamed_write_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == (ADDR_W-2)'(1)) |=> unimpl_wr);

    assert_read_no_unimpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !unimpl_wr);

endmodule

bind ccr_top ccr_chk #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata_en_bit (wdata[31]),
    .rdata        (rdata),
    .rvalid       (rvalid),
    .oob_err      (oob_err),
    .unimpl_wr    (unimpl_wr)
);

// File: tb/tb_ccr_top.sv
`timescale 1ns/1ps
module tb_ccr_top;

    localparam int NW   = 194;
    localparam int WINB = 'h308;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, oob_err, unimpl_wr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] mdl [NW];

    always #10 clk = ~clk;   // 50 MHz

    ccr_top dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .oob_err(oob_err), .unimpl_wr(unimpl_wr)
    );

    function automatic bit b_pll(int i);
        return i inside {0, 2, 4, 6, 8, 10, 14, 17, 18};
    endfunction

    function automatic bit b_named(int i);
        return b_pll(i) || i inside {20, 21, 22, 61, 63, 128, 129, 136, 137,
            138, 139, 140, 141, 143, 145, 146, 148, 152};
    endfunction

    function automatic logic [31:0] b_reset(int i);
        case (i)
            0, 8: return 32'h0000_1000;
            2: return 32'h0003_5514;
            4, 6, 14, 18: return 32'h0300_6207;
            10, 17: return 32'h0004_1811;
            20: return 32'h0001_0000;
            21: return 32'h0000_1010;
            22: return 32'h0100_0000;
            63: return 32'h8000_0000;
            128, 129: return 32'h0000_00FF;
            136: return 32'h0810_0200;
            140: return 32'h8110_4000;
            141, 145: return 32'h1010_0010;
            137, 138, 139, 143, 146: return 32'h1010_0000;
            148: return 32'h0A10_1000;
            152: return 32'h1488_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] b_shape(int i, logic [31:0] d);
        logic [31:0] v = d;
        if (b_pll(i) && d[31]) v[28] = 1'b1;   // R4
        if (i == 61) v[16] = 1'b0;            // R5
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
    task automatic step(bit rd, bit wr, logic [11:0] a, logic [31:0] d, string req);
        int i = int'(a) >> 2;
        bit inr = int'(a) < WINB;
        logic [31:0] exp_rd = (rd && inr) ? mdl[i] : 32'h0;
        rd_en = rd; wr_en = wr; addr = a; wdata = d;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check(rvalid == rd, "R2 rvalid", 32'(rvalid), 32'(rd));
        if (rd) check(rdata == exp_rd, req, rdata, exp_rd);
        check(oob_err == ((rd || wr) && !inr), "R6/R7 oob_err", 32'(oob_err),
              32'((rd || wr) && !inr));
        check(unimpl_wr == (wr && inr && !b_named(i)), "R8 unimpl_wr",
              32'(unimpl_wr), 32'(wr && inr && !b_named(i)));
        if (wr && inr) mdl[i] = b_shape(i, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0C_A11B));
        for (int i = 0; i < NW; i++) mdl[i] = b_reset(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rvalid && !oob_err && !unimpl_wr, "R2 reset outputs",
              {29'b0, rvalid, oob_err, unimpl_wr}, 32'h0);

        // R1: full reset image
        for (int i = 0; i < NW; i++) step(1, 0, 12'(i * 4), 32'h0, "R1 reset value");

        // R4: enable sets lock; enable clear stores as written
        step(0, 1, 12'h000, 32'h8000_0000, "R4");
        step(1, 0, 12'h000, 32'h0, "R4 lock after enable");
        step(0, 1, 12'h044, 32'h0000_0001, "R4");
        step(1, 0, 12'h044, 32'h0, "R4 no enable");
        step(0, 1, 12'h048, 32'hA000_0000, "R4");
        step(1, 0, 12'h048, 32'h0, "R4 lock on last PLL");
        // R5
        step(0, 1, 12'h0F4, 32'hFFFF_FFFF, "R5");
        step(1, 0, 12'h0F4, 32'h0, "R5 update bit masked");
        // R8
        step(0, 1, 12'h004, 32'h0000_A5A5, "R8");
        step(1, 0, 12'h004, 32'h0, "R8 unnamed readback");
        // R3: low address bits ignored
        step(0, 1, 12'h0FE, 32'h1234_5678, "R3");
        step(1, 0, 12'h0FD, 32'h0, "R3 low bits ignored");
        // R9: read and write same address in one cycle
        step(1, 1, 12'h050, 32'hDEAD_BEEF, "R9 old value");
        step(1, 0, 12'h050, 32'h0, "R9 new value");
        // R6 / R7 at the boundary
        step(1, 0, 12'h304, 32'h0, "R6 last in-window word");
        step(0, 1, 12'h308, 32'hFFFF_FFFF, "R7");
        step(1, 0, 12'h308, 32'h0, "R6 boundary read zero");
        step(1, 1, 12'hFFC, 32'h5555_5555, "R6 top address");
        step(1, 0, 12'h000, 32'h0, "R7 no alias after discard");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int sel = int'($urandom_range(0, 9));
            logic [11:0] a;
            bit rd = 1'($urandom);
            bit wr = 1'($urandom);
            if (sel < 7)       a = 12'($urandom_range(0, NW - 1) * 4 + $urandom_range(0, 3));
            else if (sel < 8)  a = 12'({0, 2, 4, 6, 8, 10, 14, 17, 18}[$urandom_range(0, 8)] * 4);
            else               a = 12'($urandom_range(WINB, 12'hFFF));
            step(rd, wr, a, $urandom, (int'(a) >= WINB) ? "R6 random" : "R3 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule